// File: doc/BRIEF.md
# Smartcard Fault Supervisor

This block sits beside a smartcard power sequencer and turns the raw fault flags of the analog comparators into two decisions: whether the card must be powered down at once, and whether the host may start a new power-up. Card withdrawal, low logic supply, low charge-pump supply and excessive die temperature each force the power-down request on with no delay beyond input synchronization. Excess card current is treated differently: short bursts are accepted, and a fault is raised only when the flag holds for a set number of time-base ticks.

Permission to activate carries two hold-off timers. After the card-presence contact becomes active it must stay active for a debounce interval; after the logic supply recovers, a longer power-on interval must pass. All timers advance on a one-cycle tick from a shared time base, so their lengths are parameters counted in ticks. The host's activation command is passed through as a go pulse only while permission holds, so a command issued early has no effect.

Top module: `card_fault_supervisor`

## Requirements
- R1: While reset is high and on the first cycle after it, `fault_req_o` is 1, `host_ok_o` is 0 and `act_go_o` is 0.
- R2: When the card-presence contact goes inactive, `fault_req_o` rises and `host_ok_o` falls exactly 3 clock cycles after the input change (two synchronizer stages plus the output register).
- R3: After the presence contact becomes active, `host_ok_o` stays 0 until `DEB_TICKS` ticks have been counted with presence continuously active; any inactive sample during that interval restarts the count from zero.
- R4: `act_go_o` is 1 only while `host_ok_o` is 1 and the synchronized `act_cmd_i` is 1; an activation command given during a hold-off produces no go.
- R5: `pres_pol_i` = 1 makes a high `pres_i` mean card present; `pres_pol_i` = 0 makes a low `pres_i` mean card present.
- R6: `oc_i` raises `fault_req_o` only after it has stayed 1 for `OC_TICKS` ticks; a shorter burst leaves `fault_req_o` at 0 and restarts the count, and the fault clears once `oc_i` returns to 0.
- R7: `uv_i` = 1 raises `fault_req_o` 3 cycles later; after `uv_i` returns to 0, `host_ok_o` stays 0 until `POR_TICKS + DEB_TICKS` ticks have been counted, and the same hold applies after reset.
- R8: `pump_drop_i` = 1 or `ovt_i` = 1 each raise `fault_req_o` 3 cycles later, and clearing either restores `host_ok_o` 3 cycles later with no hold-off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | One-cycle time-base strobe advancing all timers |
| pres_i | input | 1 | Card-presence contact, raw |
| pres_pol_i | input | 1 | 1: presence is high level; 0: presence is low level |
| uv_i | input | 1 | Logic-supply undervoltage flag |
| oc_i | input | 1 | Card-supply overcurrent flag |
| pump_drop_i | input | 1 | Charge-pump supply drop flag |
| ovt_i | input | 1 | Overtemperature flag |
| act_cmd_i | input | 1 | Host activation command, level |
| fault_req_o | output | 1 | Deactivation request, registered |
| host_ok_o | output | 1 | Activation permitted, registered |
| act_go_o | output | 1 | Activation command accepted, registered |

## Verification
Every immediate fault reaches `fault_req_o` on the third rising edge after the input changes, so the bench drives inputs at a falling edge and samples after the second and third following rising edges to pin that latency on both sides. Timer results depend on tick counts, not cycles: the bench spaces ticks several cycles apart and waits a few cycles after the last one, then checks that one tick short of the limit leaves the output unchanged and the limiting tick changes it. The go output follows command and permission on the same 3-cycle path and is sampled after a settling wait.

// File: rtl/sup_pkg.sv
package sup_pkg;
  typedef struct packed {
    logic pres;
    logic uv;
    logic oc;
    logic pump;
    logic ovt;
    logic cmd;
  } flags_t;

  localparam int FLAG_W = $bits(flags_t);
endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d_i;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= '0;
        else     stg[s] <= stg[s-1];
      end
    end
  endgenerate

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/sup_tick_timer.sv
module sup_tick_timer #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic tick_i,
  output logic done_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr_i)                 cnt <= '0;
    else if (tick_i && (cnt != LIM))  cnt <= cnt + 1'b1;
  end

  assign done_o = (cnt == LIM);
endmodule

// File: rtl/card_fault_supervisor.sv
module card_fault_supervisor #(
  parameter int DEB_TICKS = 8000,
  parameter int POR_TICKS = 8000,
  parameter int OC_TICKS  = 6,
  parameter int SYNC_STG  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic pres_i,
  input  logic pres_pol_i,
  input  logic uv_i,
  input  logic oc_i,
  input  logic pump_drop_i,
  input  logic ovt_i,
  input  logic act_cmd_i,
  output logic fault_req_o,
  output logic host_ok_o,
  output logic act_go_o
);
  import sup_pkg::*;

  localparam int HOLD_TICKS = POR_TICKS + DEB_TICKS;

  flags_t raw, syn;

  always_comb begin
    raw.pres = pres_i;
    raw.uv   = uv_i;
    raw.oc   = oc_i;
    raw.pump = pump_drop_i;
    raw.ovt  = ovt_i;
    raw.cmd  = act_cmd_i;
  end

  sup_sync #(.W(FLAG_W), .STAGES(SYNC_STG)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (raw),
    .q_o (syn)
  );

  logic card_in;
  logic deb_done, por_done, oc_done;
  logic fault_now, ok_now;

  // presence level meaning chosen by polarity input
  assign card_in = pres_pol_i ? syn.pres : ~syn.pres;

  sup_tick_timer #(.LIMIT(DEB_TICKS)) u_deb (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (~card_in),
    .tick_i (tick_i),
    .done_o (deb_done)
  );

  sup_tick_timer #(.LIMIT(HOLD_TICKS)) u_por (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (syn.uv),
    .tick_i (tick_i),
    .done_o (por_done)
  );

  sup_tick_timer #(.LIMIT(OC_TICKS)) u_oc (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (~syn.oc),
    .tick_i (tick_i),
    .done_o (oc_done)
  );

  assign fault_now = ~card_in | syn.uv | syn.pump | syn.ovt | oc_done;
  assign ok_now    = ~fault_now & deb_done & por_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      fault_req_o <= 1'b1;
      host_ok_o   <= 1'b0;
      act_go_o    <= 1'b0;
    end else begin
      fault_req_o <= fault_now;
      host_ok_o   <= ok_now;
      act_go_o    <= ok_now & syn.cmd;
    end
  end
endmodule

// File: rtl/card_fault_supervisor_chk.sv
module card_fault_supervisor_chk (
  input logic clk,
  input logic rst,
  input logic fault_req_o,
  input logic host_ok_o,
  input logic act_go_o,
  input logic deb_done,
  input logic por_done
);
  // R1
  reset_outputs_chk: assert property (@(posedge clk)
    rst |=> (fault_req_o && !host_ok_o && !act_go_o));

  // R2
  fault_blocks_ok_chk: assert property (@(posedge clk) disable iff (rst)
    fault_req_o |-> !host_ok_o);

  // R3
  ok_needs_debounce_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(host_ok_o) |-> $past(deb_done));

  // R4
  go_needs_ok_chk: assert property (@(posedge clk) disable iff (rst)
    act_go_o |-> host_ok_o);

  // R7
  ok_needs_por_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(host_ok_o) |-> $past(por_done));
endmodule

bind card_fault_supervisor card_fault_supervisor_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .fault_req_o (fault_req_o),
  .host_ok_o   (host_ok_o),
  .act_go_o    (act_go_o),
  .deb_done    (deb_done),
  .por_done    (por_done)
);

// File: tb/card_fault_supervisor_tb.sv
module card_fault_supervisor_tb;
  localparam int DEB = 4;
  localparam int POR = 3;
  localparam int OCT = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0, pres = 1'b0, pol = 1'b1, uv = 1'b0, oc = 1'b0;
  logic pump = 1'b0, ovt = 1'b0, cmd = 1'b0;
  logic fault_req, host_ok, act_go;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  card_fault_supervisor #(.DEB_TICKS(DEB), .POR_TICKS(POR), .OC_TICKS(OCT)) u_dut (
    .clk(clk), .rst(rst), .tick_i(tick), .pres_i(pres), .pres_pol_i(pol),
    .uv_i(uv), .oc_i(oc), .pump_drop_i(pump), .ovt_i(ovt), .act_cmd_i(cmd),
    .fault_req_o(fault_req), .host_ok_o(host_ok), .act_go_o(act_go)
  );

  task automatic check(input logic act, input logic exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", what, act, exp);
    end
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(fault_req, 1'b1, "R1 fault_req in reset");
    check(host_ok, 1'b0, "R1 host_ok in reset");
    check(act_go, 1'b0, "R1 act_go in reset");
    pres = 1'b1;
    rst = 1'b0;
    @(negedge clk);
    check(fault_req, 1'b1, "R1 fault_req after reset");
  endtask

  task automatic t_powerup();
    settle();
    ticks(DEB + POR - 1);
    check(host_ok, 1'b0, "R7 hold after reset one tick short");
    check(fault_req, 1'b0, "R7 no fault during hold");
    ticks(1);
    check(host_ok, 1'b1, "R7 ok after hold from reset");
  endtask

  task automatic t_removal();
    @(negedge clk) pres = 1'b0;
    repeat (2) @(negedge clk);
    check(fault_req, 1'b0, "R2 fault not before 3 cycles");
    @(negedge clk);
    check(fault_req, 1'b1, "R2 fault at 3 cycles");
    check(host_ok, 1'b0, "R2 ok low at 3 cycles");
    pres = 1'b1;
    settle();
    ticks(DEB - 1);
    check(host_ok, 1'b0, "R3 ok low during debounce");
    cmd = 1'b1;
    settle();
    check(act_go, 1'b0, "R4 early command ignored");
    cmd = 1'b0;
    @(negedge clk) pres = 1'b0;
    @(negedge clk) pres = 1'b1;
    settle();
    ticks(DEB - 1);
    check(host_ok, 1'b0, "R3 glitch restarted debounce");
    ticks(1);
    check(host_ok, 1'b1, "R3 ok after full debounce");
    cmd = 1'b1;
    settle();
    check(act_go, 1'b1, "R4 command accepted when ok");
    cmd = 1'b0;
    settle();
    check(act_go, 1'b0, "R4 go follows command release");
  endtask

  task automatic t_polarity();
    pol = 1'b0;
    settle();
    check(fault_req, 1'b1, "R5 high level absent with low polarity");
    pres = 1'b0;
    settle();
    check(fault_req, 1'b0, "R5 low level present with low polarity");
    ticks(DEB);
    check(host_ok, 1'b1, "R5 ok after debounce low polarity");
    pol = 1'b1;
    pres = 1'b1;
    settle();
    ticks(DEB);
  endtask

  task automatic t_overcurrent();
    oc = 1'b1;
    settle();
    ticks(OCT - 1);
    check(fault_req, 1'b0, "R6 short burst tolerated");
    check(host_ok, 1'b1, "R6 ok during short burst");
    oc = 1'b0;
    settle();
    oc = 1'b1;
    settle();
    ticks(OCT - 1);
    check(fault_req, 1'b0, "R6 count restarted after burst");
    ticks(1);
    check(fault_req, 1'b1, "R6 fault at limit");
    check(host_ok, 1'b0, "R6 ok low on fault");
    oc = 1'b0;
    settle();
    check(fault_req, 1'b0, "R6 fault clears");
    check(host_ok, 1'b1, "R6 ok returns");
  endtask

  task automatic t_undervoltage();
    @(negedge clk) uv = 1'b1;
    repeat (2) @(negedge clk);
    check(fault_req, 1'b0, "R7 uv fault not before 3 cycles");
    @(negedge clk);
    check(fault_req, 1'b1, "R7 uv fault at 3 cycles");
    uv = 1'b0;
    settle();
    check(fault_req, 1'b0, "R7 uv fault cleared");
    ticks(DEB + POR - 1);
    check(host_ok, 1'b0, "R7 hold one tick short");
    cmd = 1'b1;
    settle();
    check(act_go, 1'b0, "R4 command ignored during supply hold");
    cmd = 1'b0;
    ticks(1);
    check(host_ok, 1'b1, "R7 ok after hold");
  endtask

  task automatic t_pump_ovt();
    @(negedge clk) pump = 1'b1;
    repeat (2) @(negedge clk);
    check(fault_req, 1'b0, "R8 pump fault not before 3 cycles");
    @(negedge clk);
    check(fault_req, 1'b1, "R8 pump fault at 3 cycles");
    @(negedge clk) pump = 1'b0;
    repeat (3) @(negedge clk);
    check(host_ok, 1'b1, "R8 ok 3 cycles after pump clears");
    @(negedge clk) ovt = 1'b1;
    repeat (3) @(negedge clk);
    check(fault_req, 1'b1, "R8 ovt fault at 3 cycles");
    check(host_ok, 1'b0, "R8 ok low on ovt");
    @(negedge clk) ovt = 1'b0;
    repeat (3) @(negedge clk);
    check(host_ok, 1'b1, "R8 ok 3 cycles after ovt clears");
  endtask

  initial begin
    t_reset();
    t_powerup();
    t_removal();
    t_polarity();
    t_overcurrent();
    t_undervoltage();
    t_pump_ovt();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule